// File: doc/BRIEF.md
# Flash Program/Erase Guard

This block holds the control state of an on-chip flash array and decides, every clock, whether the array may be in program mode or erase mode. Software writes a control register and two block-mask registers through a small register port. A write-protect pin, the system reset, a watchdog-overflow reset and a standby request all force-clear these registers. These force-clear inputs therefore override anything software has set.

Three layers gate mode entry. The first is the force-clear described above. The second is a software-enable bit in the control register. The third is a per-block mask that qualifies the erase strobe. Program and erase requests are mutually exclusive, and a control word asking for both enters neither mode. A small state machine turns the stored request into the mode outputs. Its states are:
- ST_LOCK: entered whenever a force-clear input is active or reset is asserted.
- ST_IDLE: no valid request.
- ST_PROG: program mode.
- ST_ERASE: erase mode.

The state machine has these transitions:
- Any state goes to ST_LOCK when force-clear is active.
- Otherwise, every state goes to ST_PROG on a valid program request.
- Otherwise, every state goes to ST_ERASE on a valid erase request.
- Otherwise, every state goes to ST_IDLE.

The mode outputs and the per-block erase vector drive the flash array model.

Top module: `flash_guard`

## Requirements
- R1: While `wp_pin` is high, the control register and both mask registers are cleared on every clock edge. Writes are ignored and every address reads back zero.
- R2: Reset is handled as follows. A low `rst_n` clears all registers asynchronously and selects ST_LOCK. A high `wdt_rst` or `stby` at a clock edge clears all registers and selects ST_LOCK at that edge.
- R3: Whether a mode is active or not, a force-clear input (`wp_pin`, `wdt_rst` or `stby`) sampled high at an edge leaves both `prog_mode` and `erase_mode` low after that edge.
- R4: With the software-enable bit (control bit 7) clear, setting the program bit (bit 0) or the erase bit (bit 1) enters no mode.
- R5: Program entry works as follows. Suppose a control write of enable=1, program=1, erase=0 is sampled at edge k. Then `prog_mode` is high after edge k+1 and stays high while the register is unchanged and no force-clear occurs.
- R6: If the program and erase bits are both set, neither mode is entered, and `prog_mode` and `erase_mode` are never high together.
- R7: Erase entry works as follows. Suppose a control write of enable=1, erase=1, program=0 is sampled at edge k. Then `erase_mode` is high after edge k+1.
- R8: Bit i of `blk_erase` is high only while `erase_mode` is high and block i is enabled. Blocks 0 to 7 are bits 7:0 of the low mask register (address 1). Blocks 8 to 11 are bits 3:0 of the high mask register (address 2).
- R9: When both mask registers are zero, no `blk_erase` bit is set, even in erase mode.
- R10: The register map reads back as follows. Address 0 returns enable in bit 7, erase in bit 1, program in bit 0, and zero elsewhere. Address 1 returns the low mask. Address 2 returns the high mask in bits 3:0 with the upper bits zero. Address 3 reads zero.
- R11: Once the active request bit is cleared, the mode output falls one edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wdt_rst | input | 1 | Watchdog-overflow reset, synchronous |
| stby | input | 1 | Standby request |
| wp_pin | input | 1 | Hardware write-protect, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel` |
| prog_mode | output | 1 | Program-mode strobe to the array |
| erase_mode | output | 1 | Erase-mode strobe to the array |
| blk_erase | output | 12 | Per-block erase enable |

## Verification
A register write and a force-clear can land on the same clock edge. The force-clear must win, so the write is lost and the registers read zero afterwards. Likewise, an abort from the protect pin, standby or watchdog can coincide with the edge that would otherwise enter or hold a mode. Both collisions are provoked by directed cases and by random cycles in which protection pulses overlap writes. A cycle-level bench model judges every cycle: it clears first and only otherwise applies the write and the mode decode.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PROG  = 2'd2,
        ST_ERASE = 2'd3
    } fg_state_t;

    localparam int CTL_SWE_BIT = 7;
    localparam int CTL_ERS_BIT = 1;
    localparam int CTL_PRG_BIT = 0;

    localparam logic [1:0] ADDR_CTL    = 2'd0;
    localparam logic [1:0] ADDR_BLK_LO = 2'd1;
    localparam logic [1:0] ADDR_BLK_HI = 2'd2;
endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
    import flash_guard_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NBLK_A = 8,
    parameter int NBLK_B = 4,
    localparam int NBLK  = NBLK_A + NBLK_B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            force_clr,
    input  logic            reg_wr,
    input  logic [1:0]      reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            sw_en,
    output logic            prog_req,
    output logic            erase_req,
    output logic [NBLK-1:0] blk_mask
);
    logic [NBLK_A-1:0] mask_lo;
    logic [NBLK_B-1:0] mask_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_en     <= 1'b0;
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            mask_lo   <= '0;
            mask_hi   <= '0;
        end else if (force_clr) begin
            sw_en     <= 1'b0;
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            mask_lo   <= '0;
            mask_hi   <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel)
                ADDR_CTL: begin
                    sw_en     <= reg_wdata[CTL_SWE_BIT];
                    erase_req <= reg_wdata[CTL_ERS_BIT];
                    prog_req  <= reg_wdata[CTL_PRG_BIT];
                end
                ADDR_BLK_LO: mask_lo <= reg_wdata[NBLK_A-1:0];
                ADDR_BLK_HI: mask_hi <= reg_wdata[NBLK_B-1:0];
                default: ;
            endcase
        end
    end

    assign blk_mask = {mask_hi, mask_lo};

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            ADDR_CTL: begin
                reg_rdata[CTL_SWE_BIT] = sw_en;
                reg_rdata[CTL_ERS_BIT] = erase_req;
                reg_rdata[CTL_PRG_BIT] = prog_req;
            end
            ADDR_BLK_LO: reg_rdata[NBLK_A-1:0] = mask_lo;
            ADDR_BLK_HI: reg_rdata[NBLK_B-1:0] = mask_hi;
            default: ;
        endcase
    end

    // R1 / R2: a force-clear leaves every register cleared after the edge
    assert_force_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> (!sw_en && !prog_req && !erase_req && blk_mask == '0));

    // R1: nothing is readable after a force-clear edge
    assert_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> (reg_rdata == '0));

    // R10: a write to the unused address leaves the stored state untouched
    assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd3 && !force_clr) |=>
        ($stable(blk_mask) && $stable(sw_en) && $stable(prog_req) && $stable(erase_req)));
endmodule

// File: rtl/flash_guard_fsm.sv
module flash_guard_fsm
    import flash_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_clr,
    input  logic sw_en,
    input  logic prog_req,
    input  logic erase_req,
    output logic prog_mode,
    output logic erase_mode
);
    fg_state_t state, state_nx;
    logic want_prog, want_erase;

    assign want_prog  = sw_en && prog_req && !erase_req;
    assign want_erase = sw_en && erase_req && !prog_req;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCK, ST_IDLE, ST_PROG, ST_ERASE: begin
                if (force_clr)       state_nx = ST_LOCK;
                else if (want_prog)  state_nx = ST_PROG;
                else if (want_erase) state_nx = ST_ERASE;
                else                 state_nx = ST_IDLE;
            end
            default: state_nx = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCK;
        else        state <= state_nx;
    end

    always_comb begin
        prog_mode  = 1'b0;
        erase_mode = 1'b0;
        unique case (state)
            ST_PROG:  prog_mode  = 1'b1;
            ST_ERASE: erase_mode = 1'b1;
            default: ;
        endcase
    end

    // R3: protection input aborts any mode on the next edge
    assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> (!prog_mode && !erase_mode));

    // R4: software enable clear blocks entry
    assert_sw_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> (!prog_mode && !erase_mode));

    // R6: both requests together give no mode; modes never overlap
    assert_both_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && erase_req) |=> (!prog_mode && !erase_mode));
    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_mode, erase_mode}));

    // R11: dropping the program request ends program mode one edge later
    assert_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && !prog_req) |=> !prog_mode);
endmodule

// File: rtl/flash_guard_blkgate.sv
module flash_guard_blkgate #(
    parameter int NBLK = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            erase_mode,
    input  logic [NBLK-1:0] blk_mask,
    output logic [NBLK-1:0] blk_erase
);
    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        assign blk_erase[g] = erase_mode & blk_mask[g];
    end

    // R8: no block strobe outside erase mode
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_mode |-> (blk_erase == '0));

    // R9: empty mask protects every block
    assert_empty_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mask == '0) |-> (blk_erase == '0));
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter int DW     = 8,
    parameter int NBLK_A = 8,
    parameter int NBLK_B = 4,
    localparam int NBLK  = NBLK_A + NBLK_B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wdt_rst,
    input  logic            stby,
    input  logic            wp_pin,
    input  logic            reg_wr,
    input  logic [1:0]      reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            prog_mode,
    output logic            erase_mode,
    output logic [NBLK-1:0] blk_erase
);
    logic            force_clr;
    logic            sw_en, prog_req, erase_req;
    logic [NBLK-1:0] blk_mask;

    assign force_clr = wp_pin | wdt_rst | stby;

    flash_guard_regs #(.DW(DW), .NBLK_A(NBLK_A), .NBLK_B(NBLK_B)) u_regs (
        .clk(clk), .rst_n(rst_n), .force_clr(force_clr),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sw_en(sw_en), .prog_req(prog_req),
        .erase_req(erase_req), .blk_mask(blk_mask)
    );

    flash_guard_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .force_clr(force_clr),
        .sw_en(sw_en), .prog_req(prog_req), .erase_req(erase_req),
        .prog_mode(prog_mode), .erase_mode(erase_mode)
    );

    flash_guard_blkgate #(.NBLK(NBLK)) u_gate (
        .clk(clk), .rst_n(rst_n), .erase_mode(erase_mode),
        .blk_mask(blk_mask), .blk_erase(blk_erase)
    );

    // R2: watchdog or standby at an edge leaves the array idle
    assert_wdt_stby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst || stby) |=> (!prog_mode && !erase_mode && blk_erase == '0));
endmodule

// File: tb/test_flash_guard.sv
module test_flash_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_rst = 1'b0, stby = 1'b0, wp_pin = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        prog_mode, erase_mode;
    logic [11:0] blk_erase;

    int n_vec = 0;
    int n_bad = 0;

    // bench model state
    logic       m_swe = 0, m_pr = 0, m_er = 0, m_pm = 0, m_em = 0;
    logic [7:0] m_lo = 0;
    logic [3:0] m_hi = 0;

    always #10 clk = ~clk;

    flash_guard i_flash_guard (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .stby(stby), .wp_pin(wp_pin),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .prog_mode(prog_mode), .erase_mode(erase_mode),
        .blk_erase(blk_erase)
    );

    always @(posedge clk) begin
        if (!rst_n || wp_pin || wdt_rst || stby) begin
            m_swe = 0; m_pr = 0; m_er = 0; m_pm = 0; m_em = 0; m_lo = 0; m_hi = 0;
        end else begin
            m_pm = m_swe & m_pr & ~m_er;
            m_em = m_swe & m_er & ~m_pr;
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: begin m_swe = reg_wdata[7]; m_er = reg_wdata[1]; m_pr = reg_wdata[0]; end
                    2'd1: m_lo = reg_wdata;
                    2'd2: m_hi = reg_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] s);
        case (s)
            2'd0: return {m_swe, 5'd0, m_er, m_pr};
            2'd1: return m_lo;
            2'd2: return {4'd0, m_hi};
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [11:0] exp_blk();
        return m_em ? {m_hi, m_lo} : 12'd0;
    endfunction

    task automatic check(input string tag);
        logic [22:0] act, exp;
        act = {prog_mode, erase_mode, blk_erase, reg_rdata};
        exp = {m_pm, m_em, exp_blk(), exp_rd(reg_sel)};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pm/em/blk/rd actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic wp, input logic wd, input logic sb, input logic w,
                        input logic [1:0] s, input logic [7:0] d, input string tag);
        wp_pin = wp; wdt_rst = wd; stby = sb; reg_wr = w; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(input int n, input logic [1:0] s, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, s, 8'h00, tag);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        step(0, 0, 0, 0, 2'd0, 8'h00, "R2");     // reset held
        rst_n = 1'b1;
        idle(2, 2'd0, "R2");

        // R5 program entry and R10 readback of control
        step(0, 0, 0, 1, 2'd0, 8'h81, "R5");
        idle(3, 2'd0, "R10");
        // R11 exit
        step(0, 0, 0, 1, 2'd0, 8'h80, "R11");
        idle(2, 2'd0, "R11");

        // R10 masks; high register keeps only 4 bits; address 3 reads zero
        step(0, 0, 0, 1, 2'd1, 8'hA5, "R10");
        step(0, 0, 0, 1, 2'd2, 8'hFF, "R10");
        idle(1, 2'd2, "R10");
        step(0, 0, 0, 1, 2'd3, 8'hFF, "R10");
        idle(1, 2'd1, "R10");

        // R7/R8 erase with mask
        step(0, 0, 0, 1, 2'd0, 8'h82, "R7");
        idle(3, 2'd0, "R8");

        // R3/R1 protect pin during erase, writes ignored and reads zero
        step(1, 0, 0, 1, 2'd1, 8'hFF, "R3");
        step(1, 0, 0, 1, 2'd0, 8'h81, "R1");
        step(1, 0, 0, 0, 2'd1, 8'h00, "R1");
        step(1, 0, 0, 0, 2'd0, 8'h00, "R1");
        idle(2, 2'd0, "R1");

        // R4 software enable clear
        step(0, 0, 0, 1, 2'd0, 8'h01, "R4");
        idle(2, 2'd0, "R4");
        step(0, 0, 0, 1, 2'd0, 8'h02, "R4");
        idle(2, 2'd0, "R4");

        // R6 both bits set
        step(0, 0, 0, 1, 2'd0, 8'h83, "R6");
        idle(3, 2'd0, "R6");

        // R9 erase mode with empty masks
        step(0, 0, 0, 1, 2'd1, 8'h00, "R9");
        step(0, 0, 0, 1, 2'd2, 8'h00, "R9");
        step(0, 0, 0, 1, 2'd0, 8'h82, "R9");
        idle(3, 2'd0, "R9");

        // R2 watchdog and standby during program mode
        step(0, 0, 0, 1, 2'd0, 8'h81, "R5");
        idle(2, 2'd0, "R5");
        step(0, 1, 0, 0, 2'd0, 8'h00, "R2");
        idle(1, 2'd0, "R2");
        step(0, 0, 0, 1, 2'd0, 8'h81, "R5");
        idle(2, 2'd0, "R5");
        step(0, 0, 1, 1, 2'd0, 8'h81, "R2");    // write collides with standby
        idle(2, 2'd0, "R2");

        // async reset mid-mode
        step(0, 0, 0, 1, 2'd0, 8'h81, "R5");
        idle(2, 2'd0, "R5");
        rst_n = 1'b0;
        idle(1, 2'd0, "R2");
        rst_n = 1'b1;
        idle(1, 2'd0, "R2");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic wp, wd, sb, w;
            logic [1:0] s;
            logic [7:0] d;
            logic [2:0] pick;
            wp = ($urandom % 16) == 0;
            wd = ($urandom % 40) == 0;
            sb = ($urandom % 40) == 0;
            w  = ($urandom % 2) == 0;
            s  = 2'($urandom % 4);
            pick = 3'($urandom % 8);
            if (s == 2'd0) begin
                case (pick)
                    3'd0: d = 8'h83;
                    3'd1: d = 8'h01;
                    3'd2: d = 8'h02;
                    3'd3, 3'd4: d = 8'h82;
                    default: d = 8'h81;
                endcase
            end else begin
                d = 8'($urandom);
            end
            rst_n = ($urandom % 300) != 0;
            step(wp, wd, sb, w, s, d, "R8");
            rst_n = 1'b1;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule